// File: doc/BRIEF.md
# Superscalar Decode Stage Controller

This block is the control heart of a multi-wide decode stage. Each cycle fetch offers a group of up to `WIDTH` instruction slots, each with its own valid bit, PC, source-register count and branch-check flags. The stage passes the leading run of valid slots to rename. When the first slot is empty, or a slot before it is invalid, nothing past that point is forwarded. Every forwarded slot carries a can-issue flag, which is set when the instruction reads no source registers. Opcode decoding, target computation and renaming happen elsewhere.

Back-pressure works without a ready handshake. Rename, execute and commit each drive a stall line, and a stall from any of them makes the stage store incoming groups in a skid buffer. The stage then holds `fe_stall` towards fetch. Fetch may keep presenting groups while `fe_stall` is high. Every group whose first slot is valid is captured, as long as the buffer has room. Once the stalls clear, the buffered groups drain one per cycle. Only when the buffer is empty does the stage resume taking groups directly from fetch.

Commit can flush the stage with a squash request or a reorder-buffer-squashing indication. The stage can also flush itself: when a control instruction with a resolved target is flagged as mispredicted, the stage redirects fetch to that instruction's correct next PC.

Top module: `dec_stage`

## Requirements
- R1: When forwarding, slot i goes to rename only if slots 0..i are all valid, and at most `WIDTH` slots go per cycle. Slots that are not forwarded show `rn_valid` 0 with zero PC, source count and can-issue.
- R2: After reset the stage is idle with an empty buffer, and every output to rename and to fetch is 0.
- R3: In the idle, running or draining state, if any stall input is high and there is no commit squash, nothing is forwarded and the stage becomes blocked. The current fetch group is buffered if its slot 0 is valid. `fe_stall` stays 0 in that cycle.
- R4: While blocked, `fe_stall` is 1, and each fetch group whose slot 0 is valid is buffered. Fetch groups are never forwarded directly.
- R5: While blocked with all three stalls low and no squash, the next state is draining if the buffer, after this cycle's capture, holds anything. Otherwise the next state is running.
- R6: While draining with no stall and no squash:
  - The head buffered group is forwarded under the R1 rule and then popped.
  - A fetch group with slot 0 valid is appended to the buffer.
  - `fe_stall` is 1 if the buffer is still non-empty afterwards; otherwise the stage returns to running.
- R7: A commit squash in any state other than squashing, or a reorder-buffer-squashing indication while blocked, empties the buffer. The stage enters squashing and nothing is forwarded.
- R8: While squashing, nothing is forwarded, fetch groups are ignored and `fe_stall` is 0. The stage returns to running in the first cycle in which both squash inputs are low.
- R9: The first forwarded slot with control, target-resolved and mispredicted flags all set is still forwarded, and later slots are not. In that cycle `fe_squash` and `fe_mispredict` are 1 and `fe_redirect_pc` carries that slot's next PC. The buffer is emptied and the stage enters squashing.
- R10: `rn_can_issue[i]` is 1 exactly when slot i is forwarded and its source count is zero.
- R11: If a group must be buffered while the buffer already holds `DEPTH` groups and none is popped that cycle, the group is dropped and `skid_overflow` pulses for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | WIDTH | Per-slot valid from fetch |
| fe_pc | input | WIDTH*PC_W | Per-slot PC |
| fe_nsrc | input | WIDTH*SRC_W | Per-slot source register count |
| fe_is_ctrl | input | WIDTH | Slot is a control instruction |
| fe_tgt_known | input | WIDTH | Slot's target is resolved |
| fe_mispred | input | WIDTH | Slot's prediction is wrong |
| fe_next_pc | input | WIDTH*PC_W | Slot's correct next PC |
| stall_rename | input | 1 | Stall from rename |
| stall_exec | input | 1 | Stall from execute |
| stall_commit | input | 1 | Stall from commit |
| commit_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is squashing |
| rn_valid | output | WIDTH | Per-slot valid to rename |
| rn_pc | output | WIDTH*PC_W | Forwarded PCs |
| rn_nsrc | output | WIDTH*SRC_W | Forwarded source counts |
| rn_can_issue | output | WIDTH | Ready-to-issue mark per slot |
| fe_stall | output | 1 | Stall to fetch |
| fe_squash | output | 1 | Squash request to fetch |
| fe_mispredict | output | 1 | Prediction-incorrect flag to fetch |
| fe_redirect_pc | output | PC_W | Correct PC for the fetch redirect |
| skid_overflow | output | 1 | Group dropped on a full buffer |

## Verification
The stimulus mixes fetch groups with random valid patterns. Some have gaps and some have an empty slot 0, which separates prefix-stop forwarding from simple per-slot masking. Stall bursts rotate among the three sources. Their lengths range from one cycle to longer than the buffer can absorb, so the tests cover plain blocking, multi-group draining with fetch still pushing, direct return to running with an empty buffer, and overflow. Sparse commit squashes, reorder-buffer-squash pulses and mispredicted slots in random positions arrive in every state. They check flush priority over capture, that a squash stays in force while the inputs hold, and that forwarding is cut right after the offending slot.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQ    = 3'd4
  } dec_state_e;
endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int GW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [GW-1:0] wdata,
  output logic [GW-1:0] rdata,
  output logic          cnt_nz,
  output logic          cnt_gt1,
  output logic          overflow
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PTRW = $clog2(DEPTH);

  logic [GW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q;
  logic [CW-1:0]   cnt_q;
  logic            full, do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign do_push  = push & ~flush & (~full | pop);
  assign do_pop   = pop & ~flush & (cnt_q != '0);
  assign overflow = push & full & ~pop & ~flush;
  assign rdata    = mem[rd_q];
  assign cnt_nz   = (cnt_q != '0);
  assign cnt_gt1  = (cnt_q > CW'(1));

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTRW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTRW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // R11
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (cnt_q == CW'(DEPTH)));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/dec_group_fwd.sv
module dec_group_fwd #(
  parameter int W    = 4,
  parameter int PC_W = 32,
  parameter int SW   = 2
) (
  input  logic            en,
  input  logic [W-1:0]    g_valid,
  input  logic [W*PC_W-1:0] g_pc,
  input  logic [W*SW-1:0] g_nsrc,
  input  logic [W-1:0]    g_ctrl,
  input  logic [W-1:0]    g_tknown,
  input  logic [W-1:0]    g_mis,
  input  logic [W*PC_W-1:0] g_npc,
  output logic [W-1:0]    rn_valid,
  output logic [W*PC_W-1:0] rn_pc,
  output logic [W*SW-1:0] rn_nsrc,
  output logic [W-1:0]    rn_rdy,
  output logic            mis_hit,
  output logic [PC_W-1:0] mis_pc
);
  always_comb begin
    logic go;
    rn_valid = '0;
    rn_pc    = '0;
    rn_nsrc  = '0;
    rn_rdy   = '0;
    mis_hit  = 1'b0;
    mis_pc   = '0;
    go       = en;
    for (int i = 0; i < W; i++) begin
      if (go && g_valid[i]) begin
        rn_valid[i]          = 1'b1;
        rn_pc[i*PC_W +: PC_W] = g_pc[i*PC_W +: PC_W];
        rn_nsrc[i*SW +: SW]  = g_nsrc[i*SW +: SW];
        rn_rdy[i]            = (g_nsrc[i*SW +: SW] == '0);
        if (g_ctrl[i] && g_tknown[i] && g_mis[i]) begin
          mis_hit = 1'b1;
          mis_pc  = g_npc[i*PC_W +: PC_W];
          go      = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fe_v0,
  input  logic       any_stall,
  input  logic       csq,
  input  logic       rob_sq,
  input  logic       mis_hit,
  input  logic       cnt_nz,
  input  logic       cnt_gt1,
  output logic       fwd_en,
  output logic       use_skid,
  output logic       push,
  output logic       pop,
  output logic       flush,
  output logic       stall_out,
  output dec_state_e state
);
  dec_state_e nxt;

  always_comb begin
    nxt       = state;
    fwd_en    = 1'b0;
    use_skid  = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    flush     = 1'b0;
    stall_out = 1'b0;
    unique case (state)
      ST_IDLE, ST_RUN: begin
        if (csq) begin
          flush = 1'b1;
          nxt   = ST_SQ;
        end else if (any_stall) begin
          push = fe_v0;
          nxt  = ST_BLK;
        end else if (fe_v0) begin
          fwd_en = 1'b1;
          if (mis_hit) begin
            flush = 1'b1;
            nxt   = ST_SQ;
          end else begin
            nxt = ST_RUN;
          end
        end
      end
      ST_BLK: begin
        stall_out = 1'b1;
        push      = fe_v0;
        if (csq || rob_sq) begin
          flush = 1'b1;
          nxt   = ST_SQ;
        end else if (!any_stall) begin
          nxt = (cnt_nz || fe_v0) ? ST_UNBLK : ST_RUN;
        end
      end
      ST_UNBLK: begin
        if (csq) begin
          flush = 1'b1;
          nxt   = ST_SQ;
        end else if (any_stall) begin
          push = fe_v0;
          nxt  = ST_BLK;
        end else begin
          fwd_en   = 1'b1;
          use_skid = 1'b1;
          pop      = 1'b1;
          push     = fe_v0;
          if (mis_hit) begin
            flush = 1'b1;
            nxt   = ST_SQ;
          end else if (cnt_gt1 || fe_v0) begin
            stall_out = 1'b1;
          end else begin
            nxt = ST_RUN;
          end
        end
      end
      ST_SQ: begin
        if (!csq && !rob_sq) nxt = ST_RUN;
        else if (csq)        flush = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int PC_W  = 32,
  parameter int SRC_W = 2,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      fe_valid,
  input  logic [WIDTH*PC_W-1:0] fe_pc,
  input  logic [WIDTH*SRC_W-1:0] fe_nsrc,
  input  logic [WIDTH-1:0]      fe_is_ctrl,
  input  logic [WIDTH-1:0]      fe_tgt_known,
  input  logic [WIDTH-1:0]      fe_mispred,
  input  logic [WIDTH*PC_W-1:0] fe_next_pc,
  input  logic                  stall_rename,
  input  logic                  stall_exec,
  input  logic                  stall_commit,
  input  logic                  commit_squash,
  input  logic                  rob_squashing,
  output logic [WIDTH-1:0]      rn_valid,
  output logic [WIDTH*PC_W-1:0] rn_pc,
  output logic [WIDTH*SRC_W-1:0] rn_nsrc,
  output logic [WIDTH-1:0]      rn_can_issue,
  output logic                  fe_stall,
  output logic                  fe_squash,
  output logic                  fe_mispredict,
  output logic [PC_W-1:0]       fe_redirect_pc,
  output logic                  skid_overflow
);
  localparam int O_V  = 0;
  localparam int O_PC = O_V + WIDTH;
  localparam int O_NS = O_PC + WIDTH*PC_W;
  localparam int O_CT = O_NS + WIDTH*SRC_W;
  localparam int O_TK = O_CT + WIDTH;
  localparam int O_MS = O_TK + WIDTH;
  localparam int O_NP = O_MS + WIDTH;
  localparam int GW   = O_NP + WIDTH*PC_W;

  logic [GW-1:0] fe_grp, head_grp, src_grp;
  logic fwd_en, use_skid, push, pop, flush, any_stall;
  logic cnt_nz, cnt_gt1, mis_hit;
  logic [PC_W-1:0] mis_pc;
  dec_state_e st;

  assign any_stall = stall_rename | stall_exec | stall_commit;
  assign fe_grp = {fe_next_pc, fe_mispred, fe_tgt_known, fe_is_ctrl,
                   fe_nsrc, fe_pc, fe_valid};
  assign src_grp = use_skid ? head_grp : fe_grp;

  dec_skid_fifo #(.GW(GW), .DEPTH(DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wdata(fe_grp), .rdata(head_grp), .cnt_nz(cnt_nz), .cnt_gt1(cnt_gt1),
    .overflow(skid_overflow));

  dec_group_fwd #(.W(WIDTH), .PC_W(PC_W), .SW(SRC_W)) u_fwd (
    .en(fwd_en),
    .g_valid (src_grp[O_V  +: WIDTH]),
    .g_pc    (src_grp[O_PC +: WIDTH*PC_W]),
    .g_nsrc  (src_grp[O_NS +: WIDTH*SRC_W]),
    .g_ctrl  (src_grp[O_CT +: WIDTH]),
    .g_tknown(src_grp[O_TK +: WIDTH]),
    .g_mis   (src_grp[O_MS +: WIDTH]),
    .g_npc   (src_grp[O_NP +: WIDTH*PC_W]),
    .rn_valid(rn_valid), .rn_pc(rn_pc), .rn_nsrc(rn_nsrc),
    .rn_rdy(rn_can_issue), .mis_hit(mis_hit), .mis_pc(mis_pc));

  dec_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fe_v0(fe_valid[0]), .any_stall(any_stall),
    .csq(commit_squash), .rob_sq(rob_squashing), .mis_hit(mis_hit),
    .cnt_nz(cnt_nz), .cnt_gt1(cnt_gt1), .fwd_en(fwd_en),
    .use_skid(use_skid), .push(push), .pop(pop), .flush(flush),
    .stall_out(fe_stall), .state(st));

  assign fe_squash      = mis_hit;
  assign fe_mispredict  = mis_hit;
  assign fe_redirect_pc = mis_pc;

  // R4
  blk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLK) |-> fe_stall);

  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_squash |=> (rn_valid == '0));

  // R6
  unblk_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UNBLK && !commit_squash && !any_stall) |-> rn_valid[0]);

  generate
    for (genvar gi = 0; gi < WIDTH - 1; gi++) begin : g_pfx
      // R1
      rn_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rn_valid[gi+1] |-> rn_valid[gi]);
    end
  endgenerate
endmodule

// File: tb/sim_dec_stage.sv
module sim_dec_stage;
  localparam int W = 4, PW = 32, SW = 2, D = 4, NCYC = 5000;

  typedef struct packed {
    logic [W-1:0]    v, ct, tk, ms;
    logic [W*PW-1:0] pc, npc;
    logic [W*SW-1:0] ns;
  } grp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  grp_t gin;
  logic s_rn, s_ex, s_cm, csq, rob;
  logic [W-1:0] rn_valid, rn_rdy;
  logic [W*PW-1:0] rn_pc;
  logic [W*SW-1:0] rn_nsrc;
  logic fe_stall, fe_squash, fe_mis, ovf;
  logic [PW-1:0] rpc;

  dec_stage #(.WIDTH(W), .PC_W(PW), .SRC_W(SW), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .fe_valid(gin.v), .fe_pc(gin.pc),
    .fe_nsrc(gin.ns), .fe_is_ctrl(gin.ct), .fe_tgt_known(gin.tk),
    .fe_mispred(gin.ms), .fe_next_pc(gin.npc), .stall_rename(s_rn),
    .stall_exec(s_ex), .stall_commit(s_cm), .commit_squash(csq),
    .rob_squashing(rob), .rn_valid(rn_valid), .rn_pc(rn_pc),
    .rn_nsrc(rn_nsrc), .rn_can_issue(rn_rdy), .fe_stall(fe_stall),
    .fe_squash(fe_squash), .fe_mispredict(fe_mis), .fe_redirect_pc(rpc),
    .skid_overflow(ovf));

  int nchk = 0, nerr = 0;
  bit done = 0;
  int mst;
  grp_t q[$];
  logic [W-1:0] e_v, e_rdy;
  logic [W*PW-1:0] e_pc;
  logic [W*SW-1:0] e_ns;
  logic e_stall, e_sq, e_ovf;
  logic [PW-1:0] e_rpc;

  task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic fwd_model(grp_t g, output bit hit);
    hit = 0;
    for (int i = 0; i < W; i++) begin
      if (!g.v[i]) break;
      e_v[i] = 1'b1;
      e_pc[i*PW +: PW] = g.pc[i*PW +: PW];
      e_ns[i*SW +: SW] = g.ns[i*SW +: SW];
      e_rdy[i] = (g.ns[i*SW +: SW] == 0);
      if (g.ct[i] && g.tk[i] && g.ms[i]) begin
        hit = 1; e_rpc = g.npc[i*PW +: PW];
        break;
      end
    end
  endtask

  task automatic store(grp_t g);
    if (q.size() >= D) e_ovf = 1'b1;
    else q.push_back(g);
  endtask

  task automatic step_and_check();
    string tag;
    bit hit, anys, v0;
    grp_t h;
    e_v = '0; e_rdy = '0; e_pc = '0; e_ns = '0;
    e_stall = 0; e_sq = 0; e_ovf = 0; e_rpc = '0;
    anys = s_rn | s_ex | s_cm; v0 = gin.v[0]; hit = 0;
    tag = "R1";
    case (mst)
      0, 1: begin
        if (csq) begin q.delete(); mst = 4; tag = "R7"; end
        else if (anys) begin if (v0) store(gin); mst = 2; tag = "R3"; end
        else if (v0) begin
          fwd_model(gin, hit);
          if (hit) begin e_sq = 1; q.delete(); mst = 4; tag = "R9"; end
          else mst = 1;
        end
      end
      2: begin
        e_stall = 1; tag = "R4";
        if (csq || rob) begin q.delete(); mst = 4; tag = "R7"; end
        else begin
          if (v0) store(gin);
          if (!anys) begin mst = (q.size() != 0) ? 3 : 1; tag = "R5"; end
        end
      end
      3: begin
        if (csq) begin q.delete(); mst = 4; tag = "R7"; end
        else if (anys) begin if (v0) store(gin); mst = 2; tag = "R3"; end
        else begin
          tag = "R6";
          h = q.pop_front();
          fwd_model(h, hit);
          if (v0) q.push_back(gin);
          if (hit) begin e_sq = 1; q.delete(); mst = 4; tag = "R9"; end
          else if (q.size() != 0) e_stall = 1;
          else mst = 1;
        end
      end
      default: begin
        tag = "R8";
        if (!csq && !rob) mst = 1;
        else if (csq) q.delete();
      end
    endcase
    check(rn_valid === e_v, {tag, " R1 rn_valid"}, rn_valid, e_v);
    check(rn_pc === e_pc, {tag, " R1 rn_pc"}, rn_pc, e_pc);
    check(rn_nsrc === e_ns, {tag, " R1 rn_nsrc"}, rn_nsrc, e_ns);
    check(rn_rdy === e_rdy, {tag, " R10 can_issue"}, rn_rdy, e_rdy);
    check(fe_stall === e_stall, {tag, " fe_stall"}, fe_stall, e_stall);
    check(fe_squash === e_sq && fe_mis === e_sq, {tag, " R9 squash/mispredict"},
          {fe_squash, fe_mis}, {e_sq, e_sq});
    check(rpc === e_rpc, {tag, " R9 redirect_pc"}, rpc, e_rpc);
    check(ovf === e_ovf, {tag, " R11 overflow"}, ovf, e_ovf);
  endtask

  task automatic drive(bit stall_on, int which);
    gin.v = ($urandom_range(0, 4) == 0) ? '0 : W'($urandom);
    if ($urandom_range(0, 2) == 0) gin.v = '1;
    for (int i = 0; i < W; i++) begin
      gin.pc[i*PW +: PW]  = $urandom;
      gin.npc[i*PW +: PW] = $urandom;
      gin.ns[i*SW +: SW]  = SW'($urandom);
      gin.ct[i] = $urandom_range(0, 1);
      gin.tk[i] = $urandom_range(0, 1);
      gin.ms[i] = ($urandom_range(0, 12) == 0);
    end
    s_rn = stall_on && which == 0;
    s_ex = stall_on && which == 1;
    s_cm = stall_on && which == 2;
    csq  = ($urandom_range(0, 45) == 0);
    rob  = ($urandom_range(0, 40) == 0);
  endtask

  initial begin
    bit stall_on = 0;
    int which = 0;
    gin = '0; s_rn = 0; s_ex = 0; s_cm = 0; csq = 0; rob = 0;
    repeat (4) begin
      @(negedge clk);
      // R2: outputs quiet during and right after reset
      check(rn_valid == '0 && rn_rdy == '0, "R2 rn_valid reset", rn_valid, 0);
      check(!fe_stall && !fe_squash && !ovf, "R2 fetch outputs reset",
            {fe_stall, fe_squash, ovf}, 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    mst = 0;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 9) == 0) begin
        stall_on = !stall_on;
        which = $urandom_range(0, 2);
      end
      drive(stall_on, which);
      @(negedge clk);
      step_and_check();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #((NCYC + 100) * 4 * 2);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule